// File: doc/BRIEF.md
# Decapsulation Key Stream Router

This block takes the decapsulation key of a module-lattice key-encapsulation scheme as a byte stream: one byte per clock, qualified by a write enable and carrying a 12-bit byte address. The address alone decides where each byte goes. The key is made of four consecutive regions:

- the secret polynomial bytes, which go to a byte buffer;
- the encoded public key, which goes to a second byte buffer;
- a 32-byte hash of the public key, captured into a 256-bit register;
- a 32-byte implicit-rejection seed, captured into a second 256-bit register.

The region boundaries scale with the module rank K, which may be 2, 3 or 4. The rank is held steady while a key is being loaded, and the boundaries are derived from it arithmetically.

Downstream decapsulation logic uses the two wide registers directly. A readback port returns any byte of either buffer, so a test can confirm that the stream landed where it should. Hashing, polynomial decoding and the rest of decapsulation are left to other blocks.

Top module: `dk_stream_router`

## Requirements
- R1: With rank K in {2,3,4}, a written byte at address a < 384*K is stored in the secret buffer at index a.
- R2: A written byte at address 384*K <= a < 768*K+32 is stored in the public-key buffer at index a - 384*K.
- R3: A written byte at address 768*K+32+j (0 <= j < 32) is captured into hash_o bits [8j+7:8j], and no other bit of hash_o changes.
- R4: A written byte at address 768*K+64+j (0 <= j < 32) is captured into seed_o bits [8j+7:8j], and no other bit of seed_o changes.
- R5: hash_o and seed_o hold their value while writes go to the buffer regions.
- R6: Writes at addresses at or above 768*K+96 change neither capture register nor any buffer byte.
- R7: Readback with rd_sel_i=0 reads the public-key buffer and with rd_sel_i=1 the secret buffer, at index rd_idx_i. The byte appears on rd_data_o after the second rising clock edge following the presentation of the index.
- R8: An active-low synchronous reset clears hash_o and seed_o to zero and leaves both buffers' contents intact.
- R9: While rank_i holds a value outside 2..4, every write is ignored.
- R10: A cycle with wr_en_i low changes no stored state, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the capture registers |
| rank_i | input | 3 | Module rank K (2, 3 or 4), held steady during a load |
| wr_en_i | input | 1 | Byte write qualifier |
| wr_addr_i | input | 12 | Byte address within the key |
| wr_data_i | input | 8 | Key byte |
| rd_sel_i | input | 1 | Readback buffer select: 0 public key, 1 secret polynomials |
| rd_idx_i | input | 11 | Readback byte index |
| rd_data_o | output | 8 | Readback byte, two cycles after the index |
| hash_o | output | 256 | Captured public-key hash, little-endian by byte |
| seed_o | output | 256 | Captured implicit-rejection seed, little-endian by byte |

## Verification
The hardest case to expose from the ports is a write that lands in the wrong place without disturbing anything the current key depends on. Examples are a byte past the key end that leaks into the upper part of a buffer, or a write that slips through under an invalid rank. The buffers are never cleared, so the bench loads full keys in the order K = 4, then 3, then 2. The larger keys leave a known arithmetic pattern in the upper buffer indices, which a smaller rank's key never covers. The out-of-range, disabled and invalid-rank writes are then aimed at those leftover bytes, and a readback shows whether any of them was overwritten.

// File: rtl/dkr_pkg.sv
package dkr_pkg;

    // Destination of one streamed key byte
    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_SK   = 3'd1,
        RGN_PK   = 3'd2,
        RGN_HASH = 3'd3,
        RGN_SEED = 3'd4
    } rgn_e;

endpackage

// File: rtl/dkr_addr_decode.sv
module dkr_addr_decode
    import dkr_pkg::*;
#(
    parameter int RANK_W     = 3,
    parameter int RANK_MIN   = 2,
    parameter int RANK_MAX   = 4,
    parameter int POLY_BYTES = 384,
    parameter int TAG_BYTES  = 32,
    parameter int ADDR_W     = 12,
    parameter int IDX_W      = 11,
    parameter int CAP_W      = 5
) (
    input  logic [RANK_W-1:0] rank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output rgn_e              region_o,
    output logic [IDX_W-1:0]  buf_idx_o,
    output logic [CAP_W-1:0]  cap_idx_o
);

    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] k_ext;
    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] sk_end;
    logic [EXT_W-1:0] pk_end;
    logic [EXT_W-1:0] hash_end;
    logic [EXT_W-1:0] seed_end;
    logic             rank_ok;

    // Region boundaries as arithmetic functions of the rank
    always_comb begin
        k_ext    = EXT_W'(rank_i);
        a_ext    = {1'b0, addr_i};
        sk_end   = k_ext * EXT_W'(POLY_BYTES);
        pk_end   = sk_end + sk_end + EXT_W'(TAG_BYTES);
        hash_end = pk_end + EXT_W'(TAG_BYTES);
        seed_end = hash_end + EXT_W'(TAG_BYTES);
        rank_ok  = (rank_i >= RANK_W'(RANK_MIN)) && (rank_i <= RANK_W'(RANK_MAX));
    end

    always_comb begin
        region_o  = RGN_NONE;
        buf_idx_o = '0;
        cap_idx_o = '0;
        if (rank_ok) begin
            if (a_ext < sk_end) begin
                region_o  = RGN_SK;
                buf_idx_o = IDX_W'(a_ext);
            end else if (a_ext < pk_end) begin
                region_o  = RGN_PK;
                buf_idx_o = IDX_W'(a_ext - sk_end);
            end else if (a_ext < hash_end) begin
                region_o  = RGN_HASH;
                cap_idx_o = CAP_W'(a_ext - pk_end);
            end else if (a_ext < seed_end) begin
                region_o  = RGN_SEED;
                cap_idx_o = CAP_W'(a_ext - hash_end);
            end
        end
    end

endmodule

// File: rtl/dkr_byte_buffer.sv
module dkr_byte_buffer #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    localparam logic [AW:0] DEPTH_V = (AW + 1)'(DEPTH);

    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_d;
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_d = '0;
        if ({1'b0, raddr_i} < DEPTH_V) begin
            rdata_d = mem[raddr_i];
        end
    end

    always_ff @(posedge clk) begin
        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    // R2: the decoder must never address a byte outside this buffer
    a_r2_write_in_depth : assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> ({1'b0, waddr_i} < DEPTH_V));

endmodule

// File: rtl/dkr_capture_reg.sv
module dkr_capture_reg #(
    parameter int BYTES = 32,
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [7:0]           data_i,
    output logic [BYTES*8-1:0]   value_o
);

    typedef struct packed {
        logic [BYTES*8-1:0] val;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        cap_d = cap_q;
        if (we_i) begin
            cap_d.val[8*idx_i +: 8] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign value_o = cap_q.val;

    // R8: reset leaves the register at zero
    a_r8_reset_clear : assert property (@(posedge clk)
        !rst_n |=> (value_o == '0));

    // R5: without a write strobe the register holds
    a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(value_o));

endmodule

// File: rtl/dk_stream_router.sv
module dk_stream_router
    import dkr_pkg::*;
#(
    parameter int RANK_W     = 3,
    parameter int RANK_MIN   = 2,
    parameter int RANK_MAX   = 4,
    parameter int POLY_BYTES = 384,
    parameter int TAG_BYTES  = 32,
    parameter int ADDR_W     = 12,
    parameter int IDX_W      = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RANK_W-1:0]      rank_i,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic                   rd_sel_i,
    input  logic [IDX_W-1:0]       rd_idx_i,
    output logic [7:0]             rd_data_o,
    output logic [TAG_BYTES*8-1:0] hash_o,
    output logic [TAG_BYTES*8-1:0] seed_o
);

    localparam int SK_DEPTH = POLY_BYTES * RANK_MAX;
    localparam int PK_DEPTH = SK_DEPTH + TAG_BYTES;
    localparam int CAP_W    = $clog2(TAG_BYTES);
    localparam int TAG_BITS = TAG_BYTES * 8;
    localparam int EXT_W    = ADDR_W + 1;

    rgn_e             region;
    logic [IDX_W-1:0] buf_idx;
    logic [CAP_W-1:0] cap_idx;

    dkr_addr_decode #(
        .RANK_W    (RANK_W),
        .RANK_MIN  (RANK_MIN),
        .RANK_MAX  (RANK_MAX),
        .POLY_BYTES(POLY_BYTES),
        .TAG_BYTES (TAG_BYTES),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .CAP_W     (CAP_W)
    ) u_decode (
        .rank_i   (rank_i),
        .addr_i   (wr_addr_i),
        .region_o (region),
        .buf_idx_o(buf_idx),
        .cap_idx_o(cap_idx)
    );

    // Buffer 0 holds the public key, buffer 1 the secret polynomials,
    // matching the readback select encoding.
    logic [1:0] buf_we;
    logic [7:0] buf_rd [2];

    assign buf_we[0] = wr_en_i && (region == RGN_PK);
    assign buf_we[1] = wr_en_i && (region == RGN_SK);

    for (genvar g = 0; g < 2; g++) begin : g_buf
        localparam int DEP = (g == 0) ? PK_DEPTH : SK_DEPTH;
        dkr_byte_buffer #(
            .DEPTH(DEP),
            .AW   (IDX_W)
        ) u_buf (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (buf_we[g]),
            .waddr_i(buf_idx),
            .wdata_i(wr_data_i),
            .raddr_i(rd_idx_i),
            .rdata_o(buf_rd[g])
        );
    end

    // Capture 0 is the public-key hash, capture 1 the rejection seed
    logic [1:0]          cap_we;
    logic [TAG_BITS-1:0] cap_val [2];

    assign cap_we[0] = wr_en_i && (region == RGN_HASH);
    assign cap_we[1] = wr_en_i && (region == RGN_SEED);

    for (genvar g = 0; g < 2; g++) begin : g_cap
        dkr_capture_reg #(
            .BYTES(TAG_BYTES),
            .IDX_W(CAP_W)
        ) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (cap_we[g]),
            .idx_i  (cap_idx),
            .data_i (wr_data_i),
            .value_o(cap_val[g])
        );
    end

    assign hash_o = cap_val[0];
    assign seed_o = cap_val[1];

    // Readback pipeline: the select follows the buffer's registered read
    typedef struct packed {
        logic       sel;
        logic [7:0] data;
    } rd_state_t;

    rd_state_t st_d;
    rd_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sel  = rd_sel_i;
        st_d.data = buf_rd[st_q.sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data;

    // Key length and rank validity, seen from the ports
    logic [EXT_W-1:0] key_len;
    logic             rank_valid;

    always_comb begin
        key_len    = EXT_W'(rank_i) * EXT_W'(2 * POLY_BYTES) + EXT_W'(3 * TAG_BYTES);
        rank_valid = (rank_i >= RANK_W'(RANK_MIN)) && (rank_i <= RANK_W'(RANK_MAX));
    end

    // R1: a byte reaches at most one destination
    a_r1_single_target : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_we, cap_we}));

    // R6: writes past the key end leave both capture registers alone
    a_r6_past_end_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rank_valid && ({1'b0, wr_addr_i} >= key_len))
        |=> ($stable(hash_o) && $stable(seed_o)));

    // R9: an unsupported rank blocks every write
    a_r9_bad_rank_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rank_valid) |=> ($stable(hash_o) && $stable(seed_o)));

    // R10: no strobe, no change
    a_r10_idle_no_change : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(hash_o) && $stable(seed_o)));

endmodule

// File: tb/dk_stream_router_tb.sv
module dk_stream_router_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   rank_i = 3'd4;
    logic         wr_en_i = 1'b0;
    logic [11:0]  wr_addr_i = '0;
    logic [7:0]   wr_data_i = '0;
    logic         rd_sel_i = 1'b0;
    logic [10:0]  rd_idx_i = '0;
    logic [7:0]   rd_data_o;
    logic [255:0] hash_o;
    logic [255:0] seed_o;

    int checks = 0;
    int errors = 0;

    dk_stream_router u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rank_i   (rank_i),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_sel_i (rd_sel_i),
        .rd_idx_i (rd_idx_i),
        .rd_data_o(rd_data_o),
        .hash_o   (hash_o),
        .seed_o   (seed_o)
    );

    always #5 clk = ~clk;

    // Key byte pattern for address a of a rank-k key
    function automatic logic [7:0] pat(int a, int k);
        return 8'((a * 7) + (a >> 8) * 13 + k * 29 + 3);
    endfunction

    task automatic chk8(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic chk256(string req, logic [255:0] got, logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %064h expected %064h", req, got, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = 12'(a);
        wr_data_i = d;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic sel, int idx, output logic [7:0] v);
        @(negedge clk);
        wr_en_i  = 1'b0;
        rd_sel_i = sel;
        rd_idx_i = 11'(idx);
        @(posedge clk);
        @(posedge clk);
        #1 v = rd_data_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]   v;
        logic [255:0] save_h;
        logic [255:0] save_s;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk256("R8 hash after reset", hash_o, '0);
        chk256("R8 seed after reset", seed_o, '0);

        // Full key loads, largest rank first
        for (int p = 0; p < 3; p++) begin
            int k;
            k = 4 - p;
            rank_i = 3'(k);
            save_h = hash_o;
            save_s = seed_o;
            for (int a = 0; a < 768 * k + 32; a++) wr(a, pat(a, k));
            idle();
            chk256("R5 hash held over buffer writes", hash_o, save_h);
            chk256("R5 seed held over buffer writes", seed_o, save_s);
            for (int a = 768 * k + 32; a < 768 * k + 96; a++) wr(a, pat(a, k));
            idle();
            for (int j = 0; j < 32; j++) begin
                chk8("R3 hash byte", hash_o[8*j +: 8], pat(768 * k + 32 + j, k));
                chk8("R4 seed byte", seed_o[8*j +: 8], pat(768 * k + 64 + j, k));
            end
            for (int x = 0; x < 384 * k; x++) begin
                rd(1'b1, x, v);
                chk8("R1 R7 secret readback", v, pat(x, k));
            end
            for (int x = 0; x < 384 * k + 32; x++) begin
                rd(1'b0, x, v);
                chk8("R2 R7 public readback", v, pat(384 * k + x, k));
            end
        end

        // Writes past the end of a rank-2 key
        save_h = hash_o;
        save_s = seed_o;
        for (int a = 1632; a < 1732; a++) wr(a, 8'hA5);
        wr(4095, 8'hA5);
        idle();
        chk256("R6 hash after past-end writes", hash_o, save_h);
        chk256("R6 seed after past-end writes", seed_o, save_s);
        for (int x = 864; x < 964; x++) begin
            rd(1'b0, x, v);
            chk8("R6 public leftover", v, pat(1152 + x, 3));
        end
        for (int x = 768; x < 868; x++) begin
            rd(1'b1, x, v);
            chk8("R6 secret leftover", v, pat(x, 3));
        end

        // Strobe low with addresses in live regions
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_addr_i = 12'd1568;
        wr_data_i = 8'h3C;
        @(negedge clk);
        wr_addr_i = 12'd5;
        @(negedge clk);
        wr_addr_i = 12'd900;
        @(negedge clk);
        chk256("R10 hash with strobe low", hash_o, save_h);
        rd(1'b1, 5, v);
        chk8("R10 secret byte with strobe low", v, pat(5, 2));
        rd(1'b0, 900 - 768, v);
        chk8("R10 public byte with strobe low", v, pat(900, 2));

        // Unsupported ranks
        for (int r = 0; r < 8; r++) begin
            if (r < 2 || r > 4) begin
                rank_i = 3'(r);
                for (int a = 0; a < 10; a++) wr(a, 8'h5A);
                for (int a = 1568; a < 1632; a++) wr(a, 8'h5A);
                for (int a = 3104; a < 3168; a++) wr(a, 8'h5A);
                idle();
                chk256("R9 hash under bad rank", hash_o, save_h);
                chk256("R9 seed under bad rank", seed_o, save_s);
            end
        end
        rank_i = 3'd2;
        for (int x = 0; x < 10; x++) begin
            rd(1'b1, x, v);
            chk8("R9 secret byte under bad rank", v, pat(x, 2));
        end

        // Reset again: registers clear, buffers keep their bytes
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk256("R8 hash cleared", hash_o, '0);
        chk256("R8 seed cleared", seed_o, '0);
        for (int x = 0; x < 10; x++) begin
            rd(1'b1, x, v);
            chk8("R8 secret kept", v, pat(x, 2));
        end
        rd(1'b0, 0, v);
        chk8("R8 public kept", v, pat(768, 2));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule